// File: doc/BRIEF.md
# Cross-Domain Timer Enable Synchronizer

This block carries a timer on/off request from a fast bus clock domain into a slow, unrelated timer clock domain. A bus write strobe with a single data bit sets the requested state. The request crosses into the timer domain through two rising-edge flops and a falling-edge capture flop, so that a change takes effect two and a half slow clock cycles after it is written. The state that the timer domain actually holds is returned to the bus side through a two-flop chain and shown as a status bit. Software reading that bit therefore sees the real timer state and not the last value it wrote.

The block also has a fast path for slow clocks. A second write of 1 that lands within four bus cycles of a previous write of 1 sets the timer-domain enable asynchronously and at once. That forced state holds until a write of 0 arrives. Because the status lags the written value, a read-modify-write of the enable register that is issued just after a disable reads 1 and writes it back, and this turns the timer on again. The bench reproduces that hazard.

Top module: `tmr_en_sync`

## Requirements
- R1: While `rst` is high, and on the edges that follow, `tmr_en_o` and `en_stat_o` are 0 and no forced state exists.
- R2: A write of 1 captured at a `bclk` rising edge leaves `tmr_en_o` at 0 through the second following `tclk` rising edge. It sets `tmr_en_o` to 1 at the `tclk` falling edge right after that second rising edge.
- R3: A write of 0 clears `tmr_en_o` with the same timing as R2, provided no forced state is active.
- R4: `en_stat_o` takes the value of `tmr_en_o` at the second `bclk` rising edge after `tmr_en_o` changes. Right after a write, it still shows the old timer state.
- R5: A write of 1 captured 1 to 4 `bclk` cycles after an earlier write of 1, with no write of 0 between them, drives `tmr_en_o` to 1 immediately after the `bclk` edge that captures it, with no wait on `tclk`.
- R6: A write of 1 captured 5 or more `bclk` cycles after the previous write of 1 does not force the enable. It follows the R2 timing.
- R7: A forced enable stays at 1 until a write of 0. After that write, `tmr_en_o` falls only through the synchronized path of R3, so it is still 1 straight after the release.
- R8: While `wr_i` is 0, `wdata_i` has no effect on `tmr_en_o` or `en_stat_o`.
- R9: A write of 0 followed, before the status has updated, by a read of `en_stat_o` and a write of that value leaves the timer enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| tclk | input | 1 | Slow asynchronous timer clock |
| rst | input | 1 | Synchronous active-high reset, held for several `tclk` cycles |
| wr_i | input | 1 | Write strobe for the enable bit, one `bclk` cycle per write |
| wdata_i | input | 1 | Enable value to write |
| en_stat_o | output | 1 | Timer-domain enable state returned to the bus domain |
| tmr_en_o | output | 1 | Enable for the timer domain |

## Verification
The bench measures the enable latency edge by edge. It checks that the output is still old after the second slow rising edge and new after the falling edge that follows. A design with one stage too many or too few fails there. It then tests the double-write window exactly at 4 and 5 bus cycles, which catches an off-by-one in the window counter. It checks that releasing a forced enable does not drop the output early. It replays the read-modify-write hazard and expects the timer to end up enabled. A status path that echoed the written value instead of the timer state would read 0 at that point and leave the timer off.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int DEF_WIN_CYC   = 4;
  localparam int DEF_FWD_STAGE = 2;
  localparam int DEF_RET_STAGE = 2;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tsync_bus_side.sv
module tsync_bus_side #(
  parameter int WIN_CYC = tsync_pkg::DEF_WIN_CYC
) (
  input  logic bclk,
  input  logic rst,
  input  logic wr_i,
  input  logic wdata_i,
  output logic req_o,
  output logic force_o
);
  localparam int CW = tsync_pkg::cnt_width(WIN_CYC);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYC);

  logic [CW-1:0] win_q;
  logic          req_q;
  logic          force_q;
  logic          win_open;

  assign win_open = (win_q != '0);

  always_ff @(posedge bclk) begin
    if (rst) begin
      req_q   <= 1'b0;
      force_q <= 1'b0;
      win_q   <= '0;
    end else if (wr_i) begin
      req_q <= wdata_i;
      if (wdata_i) begin
        win_q <= WIN_LOAD;
        if (win_open) force_q <= 1'b1;
      end else begin
        win_q   <= '0;
        force_q <= 1'b0;
      end
    end else if (win_open) begin
      win_q <= win_q - 1'b1;
    end
  end

  assign req_o   = req_q;
  assign force_o = force_q;

  // R1
  reset_clear_chk: assert property (@(posedge bclk) rst |=> (!req_q && !force_q));
  // R5
  dbl_write_force_chk: assert property (@(posedge bclk) disable iff (rst)
    (wr_i && wdata_i && win_open) |=> force_q);
  // R7
  zero_release_chk: assert property (@(posedge bclk) disable iff (rst)
    (wr_i && !wdata_i) |=> !force_q);
  // R8
  idle_hold_chk: assert property (@(posedge bclk) disable iff (rst)
    !wr_i |=> ($stable(req_q) && (force_q || !$past(force_q))));
endmodule

// File: rtl/tsync_tmr_side.sv
module tsync_tmr_side #(
  parameter int FWD_STAGE = tsync_pkg::DEF_FWD_STAGE
) (
  input  logic tclk,
  input  logic rst,
  input  logic req_i,
  input  logic force_i,
  output logic tmr_en_o
);
  logic [FWD_STAGE-1:0] chain_q;
  logic                 en_q;

  always_ff @(posedge tclk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[FWD_STAGE-2:0], req_i};
  end

  // half-cycle capture on the falling edge, asynchronously set by the bypass
  always_ff @(negedge tclk or posedge force_i) begin
    if (force_i)  en_q <= 1'b1;
    else if (rst) en_q <= 1'b0;
    else          en_q <= chain_q[FWD_STAGE-1];
  end

  assign tmr_en_o = en_q;

  // R1
  tdom_reset_chk: assert property (@(posedge tclk) rst |=> (chain_q == '0));
endmodule

// File: rtl/tsync_return.sv
module tsync_return #(
  parameter int RET_STAGE = tsync_pkg::DEF_RET_STAGE
) (
  input  logic bclk,
  input  logic rst,
  input  logic tmr_en_i,
  output logic stat_o
);
  logic [RET_STAGE-1:0] ret_q;

  always_ff @(posedge bclk) begin
    if (rst) ret_q <= '0;
    else     ret_q <= {ret_q[RET_STAGE-2:0], tmr_en_i};
  end

  assign stat_o = ret_q[RET_STAGE-1];
endmodule

// File: rtl/tmr_en_sync.sv
module tmr_en_sync #(
  parameter int WIN_CYC   = tsync_pkg::DEF_WIN_CYC,
  parameter int FWD_STAGE = tsync_pkg::DEF_FWD_STAGE,
  parameter int RET_STAGE = tsync_pkg::DEF_RET_STAGE
) (
  input  logic bclk,
  input  logic tclk,
  input  logic rst,
  input  logic wr_i,
  input  logic wdata_i,
  output logic en_stat_o,
  output logic tmr_en_o
);
  logic req_w;
  logic force_w;
  logic en_w;

  tsync_bus_side #(.WIN_CYC(WIN_CYC)) u_bus (
    .bclk(bclk), .rst(rst), .wr_i(wr_i), .wdata_i(wdata_i),
    .req_o(req_w), .force_o(force_w)
  );

  tsync_tmr_side #(.FWD_STAGE(FWD_STAGE)) u_tmr (
    .tclk(tclk), .rst(rst), .req_i(req_w), .force_i(force_w),
    .tmr_en_o(en_w)
  );

  tsync_return #(.RET_STAGE(RET_STAGE)) u_ret (
    .bclk(bclk), .rst(rst), .tmr_en_i(en_w), .stat_o(en_stat_o)
  );

  assign tmr_en_o = en_w;

  // R5
  forced_on_chk: assert property (@(posedge bclk) disable iff (rst)
    force_w |-> en_w);
endmodule

// File: tb/tmr_en_sync_test.sv
`timescale 1ns/1ps
module tmr_en_sync_test;
  logic bclk = 1'b0;
  logic tclk = 1'b0;
  logic rst = 1'b1;
  logic wr_i = 1'b0;
  logic wdata_i = 1'b0;
  logic en_stat_o, tmr_en_o;

  int n_run = 0;
  int n_fail = 0;
  logic last_val = 1'b0;
  logic rd;

  always #5 bclk = ~bclk;
  initial begin
    #1;
    forever #85 tclk = ~tclk;
  end

  tmr_en_sync uut (
    .bclk(bclk), .tclk(tclk), .rst(rst), .wr_i(wr_i), .wdata_i(wdata_i),
    .en_stat_o(en_stat_o), .tmr_en_o(tmr_en_o)
  );

  function automatic logic gap_forces(input int gap);
    return (gap >= 1) && (gap <= 4);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write(input logic d);
    @(negedge bclk);
    wr_i = 1'b1;
    wdata_i = d;
    @(posedge bclk);
    #1;
    wr_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge tclk);
    repeat (3) @(posedge bclk);
    #1;
  endtask

  task automatic timed_write(input logic d, input string req);
    logic old;
    old = tmr_en_o;
    write(d);
    check({req, " old state after write"}, en_stat_o, old);
    repeat (2) @(posedge tclk);
    #1;
    check({req, " unchanged at 2nd tclk rise"}, tmr_en_o, old);
    @(negedge tclk);
    #1;
    check({req, " changed at tclk fall"}, tmr_en_o, d);
    @(posedge bclk);
    #1;
    check("R4 status one bclk after change", en_stat_o, old);
    @(posedge bclk);
    #1;
    check("R4 status two bclk after change", en_stat_o, d);
  endtask

  task automatic pair(input int gap, input string req);
    write(1'b1);
    repeat (gap - 1) @(posedge bclk);
    write(1'b1);
    check(req, tmr_en_o, gap_forces(gap));
  endtask

  initial begin
    fork
      begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      begin
        void'($urandom(32'h5EED));
        repeat (5) @(posedge tclk);
        #1;
        check("R1 tmr_en in reset", tmr_en_o, 1'b0);
        check("R1 status in reset", en_stat_o, 1'b0);
        @(negedge bclk);
        rst = 1'b0;
        settle();
        check("R1 tmr_en after reset", tmr_en_o, 1'b0);

        timed_write(1'b1, "R2");
        settle();
        timed_write(1'b0, "R3");
        settle();

        // R6: window boundary, gap 5 is not a double write
        pair(5, "R6 gap5 no force");
        settle();
        check("R6 synced on after gap5", tmr_en_o, 1'b1);
        write(1'b0);
        settle();

        // R5: gap 4 forces at once
        pair(4, "R5 gap4 forced");
        settle();
        check("R7 forced held", tmr_en_o, 1'b1);
        check("R7 forced status", en_stat_o, 1'b1);
        write(1'b0);
        check("R7 no drop at release", tmr_en_o, 1'b1);
        settle();
        check("R7 off after release", tmr_en_o, 1'b0);

        pair(1, "R5 gap1 forced");
        write(1'b0);
        settle();
        check("R7 off after gap1 release", tmr_en_o, 1'b0);

        // R8: data toggling without strobe
        for (int i = 0; i < 20; i++) begin
          @(negedge bclk);
          wdata_i = 1'($urandom);
        end
        wdata_i = 1'b1;
        settle();
        check("R8 en ignores data", tmr_en_o, 1'b0);
        check("R8 status ignores data", en_stat_o, 1'b0);

        // random single writes, spaced past the window
        last_val = 1'b0;
        for (int i = 0; i < 30; i++) begin
          logic d;
          d = 1'($urandom);
          write(d);
          last_val = d;
          repeat (5 + ($urandom % 6)) @(posedge bclk);
          if (i % 5 == 4) begin
            settle();
            check("R2 random en", tmr_en_o, last_val);
            check("R4 random status", en_stat_o, last_val);
          end
        end
        write(1'b1);
        settle();

        // R9: read-modify-write right after a disable
        write(1'b0);
        #1;
        rd = en_stat_o;
        check("R9 status still 1 at read", rd, 1'b1);
        write(rd);
        settle();
        check("R9 timer re-enabled", tmr_en_o, 1'b1);
        check("R9 status re-enabled", en_stat_o, 1'b1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule